// File: doc/BRIEF.md
# CAN Bit Timing and Resynchronization Unit

This unit divides the system clock into time quanta and walks each nominal bit of a CAN-style bus through three segments: a one-quantum synchronization segment, a first timing segment that holds propagation delay and phase segment 1, and a second timing segment that is phase segment 2. It captures the receive line at the boundary between the two timing segments. It pulses a strobe when a new bit begins, so the transmit side can launch its next bit on that strobe.

The receive line is taken as already synchronized to the clock. A high level is recessive and a low level is dominant. Falling edges, from recessive to dominant, realign the bit. An edge that arrives late stretches the first timing segment. An edge that arrives early trims the second timing segment. Each adjustment is limited by the programmed jump width. While the bus is idle, the controller raises the hard-synchronization input, and the next falling edge restarts the bit outright.

The sampled bit leaves as a one-cycle strobe, `rx_valid_o` with `rx_bit_o`. This output has no ready signal and no back-pressure: a consumer must take the bit in the cycle the strobe is high. `rx_bit_o` holds its value until the next sample. Configuration inputs must stay stable while the unit runs. They are changed only during reset.

Top module: `can_bit_timing`

## Requirements
- R1: `tq_tick_o` is high for exactly one clock in every `brp_i`+1 clocks. One time quantum is the interval from one tick to the next.
- R2: `seg_o` steps through the codes 0 (sync, 1 quantum), then 1 (first timing segment, `tseg1_i`+1 quanta), then 2 (second timing segment, `tseg2_i`+1 quanta). Code 3 never appears, and the code changes only on the clock after a tick.
- R3: When no falling edge occurs, two consecutive `bit_start_o` pulses are (`brp_i`+1)·(3+`tseg1_i`+`tseg2_i`) clocks apart.
- R4: `rx_valid_o` is high for one clock, in the clock after the tick that ends code 1. In that same clock `rx_bit_o` shows the level `rx_i` had at that tick. `rx_bit_o` holds this value until the next sample. On a nominal bit, `rx_valid_o` comes (`brp_i`+1)·(2+`tseg1_i`) clocks after `bit_start_o`.
- R5: `bit_start_o` is high for one clock, in the clock after the tick that ends code 2, and `seg_o` is 0 in that clock.
- R6: A falling edge of `rx_i` in quantum q of code 1 (q counted from 0) lengthens code 1 by min(q+1, `sjw_i`+1) quanta. An edge is attributed to the quantum in whose clocks it is seen, up to and including the tick clock.
- R7: A falling edge in quantum q of code 2 shortens code 2 by min(`tseg2_i`−q, `sjw_i`+1) quanta.
- R8: Only the first falling edge of a bit has any effect. That includes an edge in the sync quantum, which moves nothing. Rising edges are ignored.
- R9: When `hard_sync_i` is high, a falling edge in any segment makes its quantum the sync quantum of a new bit, with no jump-width limit. Code 1 follows at position 0, and no further adjustment is made in that bit.
- R10: While `rst_n` is low, `seg_o` is 0, `rx_valid_o` and `bit_start_o` are 0, and `rx_bit_o` is 1 (recessive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_i | input | 1 | Synchronized receive line, 1 = recessive |
| hard_sync_i | input | 1 | Bus idle: next falling edge hard-synchronizes |
| brp_i | input | BRP_W (6) | Prescaler, quantum = value+1 clocks |
| tseg1_i | input | T1_W (4) | First timing segment, value+1 quanta |
| tseg2_i | input | T2_W (3) | Second timing segment, value+1 quanta |
| sjw_i | input | SJW_W (2) | Jump width, value+1 quanta |
| tq_tick_o | output | 1 | Last clock of the current quantum |
| rx_bit_o | output | 1 | Most recent sampled bus level |
| rx_valid_o | output | 1 | One-clock strobe for a new sample |
| bit_start_o | output | 1 | One-clock strobe: a new bit begins |
| seg_o | output | 2 | Current segment code (0 sync, 1 first, 2 second) |

## Verification
The bench uses the default field widths: a 6-bit prescaler, a 4-bit first segment, a 3-bit second segment and a 2-bit jump width. It programs prescaler values of 0, 1, 2 and 5. A value of 0 makes every clock a tick, so an edge falls in the tick clock itself; larger values put an edge partway through a quantum. Short second segments paired with wide jump widths let the phase error, rather than the limit, set the shortening. The reverse pairing shows the limit cutting a late edge short. Hard synchronization is exercised from both timing segments.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  typedef enum logic [1:0] {
    SEG_SYNC = 2'd0,
    SEG_TS1  = 2'd1,
    SEG_TS2  = 2'd2
  } seg_e;
endpackage

// File: rtl/cbt_prescaler.sv
// Divides the clock by div_i+1; tick_o marks the last clock of each quantum.
module cbt_prescaler #(
  parameter int BRP_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BRP_W-1:0] div_i,
  output logic             tick_o
);
  logic [BRP_W-1:0] cnt_q;

  assign tick_o = (cnt_q == div_i);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + BRP_W'(1);
  end
endmodule

// File: rtl/cbt_edge_detect.sv
// Notes recessive-to-dominant transitions and holds them until the quantum ends.
module cbt_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_i,
  input  logic tick_i,
  output logic edge_o
);
  logic prev_q;
  logic pend_q;
  logic fall;

  assign fall   = prev_q & ~rx_i;
  assign edge_o = pend_q | fall;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      prev_q <= rx_i;
      pend_q <= tick_i ? 1'b0 : (pend_q | fall);
    end
  end
endmodule

// File: rtl/cbt_bit_fsm.sv
// Segment sequencer with phase-error correction, one step per quantum.
module cbt_bit_fsm
  import cbt_pkg::*;
#(
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             edge_i,
  input  logic             hard_sync_i,
  input  logic             rx_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output seg_e             seg_o,
  output logic             smp_valid_o,
  output logic             smp_bit_o,
  output logic             bit_start_o
);
  localparam int MAX_W = (T1_W > T2_W) ? ((T1_W > SJW_W) ? T1_W : SJW_W)
                                       : ((T2_W > SJW_W) ? T2_W : SJW_W);
  localparam int Q_W = MAX_W + 1;

  seg_e         seg_q, seg_n;
  logic [Q_W-1:0] pos_q, pos_n;
  logic [Q_W-1:0] adj_q, adj_n;
  logic         used_q, used_n;
  logic         val_q, val_n;
  logic         bit_q, bit_n;
  logic         bs_q, bs_n;

  logic [Q_W-1:0] t1, t2, jw;
  logic [Q_W-1:0] late_err, late_adj;
  logic [Q_W-1:0] early_err, early_adj;
  logic [Q_W-1:0] eff_adj;
  logic           resync;

  assign t1 = Q_W'(tseg1_i);
  assign t2 = Q_W'(tseg2_i);
  assign jw = Q_W'(sjw_i) + Q_W'(1);

  assign resync    = edge_i & ~used_q;
  assign late_err  = pos_q + Q_W'(1);
  assign late_adj  = (late_err < jw) ? late_err : jw;
  assign early_err = (t2 > pos_q) ? (t2 - pos_q) : '0;
  assign early_adj = (early_err < jw) ? early_err : jw;

  always_comb begin
    seg_n   = seg_q;
    pos_n   = pos_q;
    adj_n   = adj_q;
    used_n  = used_q;
    val_n   = 1'b0;
    bit_n   = bit_q;
    bs_n    = 1'b0;
    eff_adj = adj_q;
    if (tick_i) begin
      if (hard_sync_i && edge_i) begin
        seg_n  = SEG_TS1;
        pos_n  = '0;
        adj_n  = '0;
        used_n = 1'b1;
      end else begin
        unique case (seg_q)
          SEG_SYNC: begin
            seg_n  = SEG_TS1;
            pos_n  = '0;
            used_n = used_q | edge_i;
          end
          SEG_TS1: begin
            if (resync) begin
              eff_adj = late_adj;
              used_n  = 1'b1;
            end
            if (pos_q >= t1 + eff_adj) begin
              seg_n = SEG_TS2;
              pos_n = '0;
              adj_n = '0;
              val_n = 1'b1;
              bit_n = rx_i;
            end else begin
              pos_n = pos_q + Q_W'(1);
              adj_n = eff_adj;
            end
          end
          SEG_TS2: begin
            if (resync) begin
              eff_adj = early_adj;
              used_n  = 1'b1;
            end
            if (pos_q + eff_adj >= t2) begin
              seg_n  = SEG_SYNC;
              pos_n  = '0;
              adj_n  = '0;
              used_n = 1'b0;
              bs_n   = 1'b1;
            end else begin
              pos_n = pos_q + Q_W'(1);
              adj_n = eff_adj;
            end
          end
          default: begin
            seg_n  = SEG_SYNC;
            pos_n  = '0;
            adj_n  = '0;
            used_n = 1'b0;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_q  <= SEG_SYNC;
      pos_q  <= '0;
      adj_q  <= '0;
      used_q <= 1'b0;
      val_q  <= 1'b0;
      bit_q  <= 1'b1;
      bs_q   <= 1'b0;
    end else begin
      seg_q  <= seg_n;
      pos_q  <= pos_n;
      adj_q  <= adj_n;
      used_q <= used_n;
      val_q  <= val_n;
      bit_q  <= bit_n;
      bs_q   <= bs_n;
    end
  end

  assign seg_o       = seg_q;
  assign smp_valid_o = val_q;
  assign smp_bit_o   = bit_q;
  assign bit_start_o = bs_q;
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import cbt_pkg::*;
#(
  parameter int BRP_W = 6,
  parameter int T1_W  = 4,
  parameter int T2_W  = 3,
  parameter int SJW_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_i,
  input  logic             hard_sync_i,
  input  logic [BRP_W-1:0] brp_i,
  input  logic [T1_W-1:0]  tseg1_i,
  input  logic [T2_W-1:0]  tseg2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             tq_tick_o,
  output logic             rx_bit_o,
  output logic             rx_valid_o,
  output logic             bit_start_o,
  output logic [1:0]       seg_o
);
  logic tick;
  logic fall_seen;
  seg_e seg;

  cbt_prescaler #(.BRP_W(BRP_W)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .div_i  (brp_i),
    .tick_o (tick)
  );

  cbt_edge_detect u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .rx_i   (rx_i),
    .tick_i (tick),
    .edge_o (fall_seen)
  );

  cbt_bit_fsm #(.T1_W(T1_W), .T2_W(T2_W), .SJW_W(SJW_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_i      (tick),
    .edge_i      (fall_seen),
    .hard_sync_i (hard_sync_i),
    .rx_i        (rx_i),
    .tseg1_i     (tseg1_i),
    .tseg2_i     (tseg2_i),
    .sjw_i       (sjw_i),
    .seg_o       (seg),
    .smp_valid_o (rx_valid_o),
    .smp_bit_o   (rx_bit_o),
    .bit_start_o (bit_start_o)
  );

  assign tq_tick_o = tick;
  assign seg_o     = seg;
endmodule

// File: rtl/cbt_checker.sv
module cbt_checker #(
  parameter int BRP_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [BRP_W-1:0] brp_i,
  input logic             tq_tick_o,
  input logic             rx_valid_o,
  input logic             bit_start_o,
  input logic [1:0]       seg_o
);
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (tq_tick_o && brp_i != '0) |=> !tq_tick_o); // R1
  AST_SEG_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    seg_o != 2'd3); // R2
  AST_SEG_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_o != $past(seg_o)) |-> $past(tq_tick_o)); // R2
  AST_SAMPLE_IN_TS2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> seg_o == 2'd2); // R4
  AST_START_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start_o |-> seg_o == 2'd0); // R5
  AST_STROBES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_valid_o && bit_start_o)); // R4
endmodule

bind can_bit_timing cbt_checker #(.BRP_W(BRP_W)) u_cbt_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .brp_i       (brp_i),
  .tq_tick_o   (tq_tick_o),
  .rx_valid_o  (rx_valid_o),
  .bit_start_o (bit_start_o),
  .seg_o       (seg_o)
);

// File: tb/tb_can_bit_timing.sv
module tb_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       hs = 1'b0;
  logic [5:0] brp = 6'd1;
  logic [3:0] t1 = 4'd4;
  logic [2:0] t2 = 3'd2;
  logic [1:0] sjw = 2'd1;
  logic       tq_tick, rx_bit, rx_valid, bit_start;
  logic [1:0] seg;

  always #5 clk = ~clk;

  can_bit_timing dut (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .hard_sync_i(hs),
    .brp_i(brp), .tseg1_i(t1), .tseg2_i(t2), .sjw_i(sjw),
    .tq_tick_o(tq_tick), .rx_bit_o(rx_bit), .rx_valid_o(rx_valid),
    .bit_start_o(bit_start), .seg_o(seg)
  );

  int total = 0;
  int bad = 0;
  string cmp_tag = "R2 R4 R5";

  // behavioural reference: quantum phase, segment, position, adjustment
  int m_p = 0, m_seg = 0, m_q = 0, m_adj = 0, m_used = 0;
  int m_prev = 1, m_pend = 0, m_val = 0, m_bit = 1, m_bs = 0;

  always @(posedge clk) begin : ref_model
    int tick, fall, ev, a, err, jw;
    if (!rst_n) begin
      m_p = 0; m_seg = 0; m_q = 0; m_adj = 0; m_used = 0;
      m_prev = 1; m_pend = 0; m_val = 0; m_bit = 1; m_bs = 0;
    end else begin
      tick = (m_p == int'(brp)) ? 1 : 0;
      fall = (m_prev == 1 && rx == 1'b0) ? 1 : 0;
      ev = (m_pend != 0 || fall != 0) ? 1 : 0;
      m_val = 0; m_bs = 0;
      m_p = tick ? 0 : m_p + 1;
      m_pend = tick ? 0 : ev;
      m_prev = int'(rx);
      if (tick) begin
        jw = int'(sjw) + 1;
        if (hs && ev) begin
          m_seg = 1; m_q = 0; m_adj = 0; m_used = 1;
        end else if (m_seg == 0) begin
          m_seg = 1; m_q = 0;
          if (ev) m_used = 1;
        end else if (m_seg == 1) begin
          a = m_adj;
          if (ev && !m_used) begin
            err = m_q + 1; a = (err < jw) ? err : jw; m_used = 1;
          end
          if (m_q >= int'(t1) + a) begin
            m_seg = 2; m_q = 0; m_adj = 0; m_val = 1; m_bit = int'(rx);
          end else begin
            m_q++; m_adj = a;
          end
        end else begin
          a = m_adj;
          if (ev && !m_used) begin
            err = int'(t2) - m_q; if (err < 0) err = 0;
            a = (err < jw) ? err : jw; m_used = 1;
          end
          if (m_q + a >= int'(t2)) begin
            m_seg = 0; m_q = 0; m_adj = 0; m_used = 0; m_bs = 1;
          end else begin
            m_q++; m_adj = a;
          end
        end
      end
    end
  end

  always @(negedge clk) begin : compare
    int et;
    if (rst_n) begin
      et = (m_p == int'(brp)) ? 1 : 0;
      total++;
      if (int'(tq_tick) != et || int'(seg) != m_seg || int'(rx_valid) != m_val ||
          int'(bit_start) != m_bs || int'(rx_bit) != m_bit) begin
        bad++;
        $display("FAIL %s per-cycle act tick=%0d seg=%0d val=%0d bs=%0d bit=%0d exp tick=%0d seg=%0d val=%0d bs=%0d bit=%0d",
                 cmp_tag, tq_tick, seg, rx_valid, bit_start, rx_bit, et, m_seg, m_val, m_bs, m_bit);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset(input int b, input int s1, input int s2, input int j);
    @(negedge clk);
    rst_n = 1'b0; rx = 1'b1; hs = 1'b0;
    brp = 6'(b); t1 = 4'(s1); t2 = 3'(s2); sjw = 2'(j);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_bs();
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      if (bit_start) break;
    end
  endtask

  // Called at the negedge where bit_start is seen; drives falls/rises at offsets
  // (clocks from that bit start) and returns the clocks to the next bit start.
  task automatic run_bit(input int f1, input int r1, input int f2, input int r2,
                         output int len, output int vt, output int vb);
    int n;
    n = 0; vt = -1; vb = -1; len = -1;
    if (f1 == 0) rx = 1'b0;
    while (n < 5000) begin
      @(negedge clk);
      n++;
      if (rx_valid && vt < 0) begin vt = n; vb = int'(rx_bit); end
      if (bit_start) begin len = n; break; end
      if (n == f1 || n == f2) rx = 1'b0;
      if (n == r1 || n == r2) rx = 1'b1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int len, vt, vb, gap;
    void'($urandom(32'd11));
    // R10 reset state
    repeat (2) @(negedge clk);
    chk(seg == 2'd0 && !rx_valid && !bit_start && rx_bit, "R10",
        {seg, rx_valid, bit_start, rx_bit}, 1);
    do_reset(1, 4, 2, 1);
    wait_bs();
    // R1 tick spacing
    gap = 0;
    while (!tq_tick) @(negedge clk);
    @(negedge clk); gap = 1;
    while (!tq_tick) begin @(negedge clk); gap++; end
    chk(gap == 2, "R1", gap, 2);
    wait_bs();
    cmp_tag = "R3";
    run_bit(-1, -1, -1, -1, len, vt, vb);
    chk(len == 18, "R3 nominal bit", len, 18);
    chk(vt == 12, "R4 sample offset", vt, 12);
    chk(vb == 1, "R4 sampled recessive", vb, 1);
    cmp_tag = "R8";
    run_bit(0, 14, -1, -1, len, vt, vb);
    chk(len == 18, "R8 sync-quantum edge keeps length", len, 18);
    chk(vb == 0, "R4 sampled dominant", vb, 0);
    cmp_tag = "R6";
    run_bit(6, 8, -1, -1, len, vt, vb);
    chk(len == 22, "R6 late edge limited by jump width", len, 22);
    chk(vt == 16, "R6 sample point moved", vt, 16);
    run_bit(2, 4, -1, -1, len, vt, vb);
    chk(len == 20, "R6 late edge by one quantum", len, 20);
    cmp_tag = "R7";
    run_bit(12, 13, -1, -1, len, vt, vb);
    chk(len == 14, "R7 early edge shrink two", len, 14);
    run_bit(14, 15, -1, -1, len, vt, vb);
    chk(len == 16, "R7 early edge shrink one", len, 16);
    cmp_tag = "R8";
    run_bit(2, 4, 12, 13, len, vt, vb);
    chk(len == 20, "R8 second edge ignored", len, 20);
    run_bit(0, 3, 6, 8, len, vt, vb);
    chk(len == 18, "R8 edge after sync edge ignored", len, 18);
    cmp_tag = "R9";
    hs = 1'b1;
    run_bit(14, 15, -1, -1, len, vt, vb);
    chk(len == 32, "R9 hard sync from second segment", len, 32);
    run_bit(6, 8, -1, -1, len, vt, vb);
    chk(len == 24, "R9 hard sync from first segment", len, 24);
    hs = 1'b0;
    // R3 with another prescaler
    do_reset(5, 3, 1, 0);
    wait_bs();
    cmp_tag = "R3";
    run_bit(-1, -1, -1, -1, len, vt, vb);
    chk(len == 42, "R3 nominal bit prescaler 6", len, 42);
    chk(vt == 30, "R4 sample offset prescaler 6", vt, 30);
    // mixed traffic against the reference model
    cmp_tag = "R6 R7 R8 R9";
    for (int k = 0; k < 8; k++) begin
      int bv;
      bv = (k % 3 == 0) ? 0 : ((k % 3 == 1) ? 2 : 5);
      do_reset(bv, int'($urandom % 16), int'($urandom % 8), int'($urandom % 4));
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if ($urandom % 9 == 0) rx = ~rx;
        hs = (k % 2 == 1) ? (($urandom % 4) == 0) : 1'b0;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule